// File: doc/BRIEF.md
# Post-Modify Load Address Generator

This block computes, in one combinational pass, the effective address of a single load and the value the pointer register should take afterwards. It serves the address stage of a load pipeline. The decoder supplies the addressing mode, the access size as a log2 value, the pointer (base) register, an index register, the instruction immediates, a modifier register and a circular-start register. The block returns the address to send to memory, the updated pointer and a write enable for that pointer. The memory access itself happens elsewhere.

Eight modes are supported. Two compute an address without touching the pointer: base plus a size-scaled signed offset, and a shifted index plus an unsigned immediate. One loads an absolute address and also writes it to the pointer. The other five use the current pointer as the address and then advance it. They advance by a scaled signed immediate, by the modifier register, by the modifier register with the low address bits presented bit-reversed, or by a circular-buffer update. For the circular update the increment comes either from the immediate or from a field packed into the modifier register beside the buffer length.

Top module: `ldaddr_gen`

## Requirements
- R1: Mode is a 3-bit code: 0 base+offset, 1 scaled index, 2 absolute-set, 3 post-increment by immediate, 4 post-increment by modifier, 5 bit-reversed, 6 circular by immediate, 7 circular by packed field. For modes 0 and 1 the pointer-write enable is 0 and the new pointer equals the base input. For modes 2 to 7 the enable is 1.
- R2: In mode 0 the address is base plus the 11-bit signed offset, sign-extended and shifted left by the size log2.
- R3: In mode 1 the address is the index shifted left by the 2-bit shift amount, plus the zero-extended 6-bit unsigned immediate, modulo 2^32.
- R4: In mode 2 the address and the new pointer both equal the zero-extended 6-bit unsigned immediate.
- R5: In mode 3 the new pointer is base plus the 4-bit signed increment, sign-extended and shifted left by the size log2.
- R6: In mode 4 the new pointer is base plus the full 32-bit modifier register, modulo 2^32.
- R7: In mode 5 the address is the base with bits 15:0 reversed in order (bit 0 swaps with bit 15) and bits 31:16 unchanged. The new pointer is base plus the modifier. With a modifier of 0x2000 and a pointer starting at 0, successive addresses are 0, 4, 2, 6.
- R8: In modes 6 and 7 the new pointer stays within [start, start+length), where the length is modifier bits 16:0. It returns to start + (offset+increment-length) once the sum reaches the length. In mode 6 the increment is the scaled 4-bit signed immediate.
- R9: In modes 6 and 7 a negative increment that takes the offset below zero wraps by adding the length. The result lands near the top of the buffer.
- R10: In mode 7 the increment is modifier bits 23:17, read as a 7-bit two's-complement value and shifted left by the size log2. Modifier bits 31:24 have no effect.
- R11: In modes 3, 4, 6 and 7 the address equals the base input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Addressing mode code (R1) |
| size_lg2_i | input | 2 | log2 of the access size in bytes |
| base_i | input | 32 | Current pointer / base register |
| index_i | input | 32 | Index register for scaled-index mode |
| shamt_i | input | 2 | Index shift amount |
| ofs_i | input | 11 | Signed offset for base+offset mode |
| uimm_i | input | 6 | Unsigned immediate |
| sinc_i | input | 4 | Signed post-increment immediate |
| modreg_i | input | 32 | Modifier register (increment, or packed length and increment) |
| cstart_i | input | 32 | Circular buffer start address |
| ea_o | output | 32 | Effective address |
| ptr_nxt_o | output | 32 | Updated pointer value |
| ptr_we_o | output | 1 | Pointer write enable |

## Verification
The bench aims at the wrap points of the circular modes: an upward step that lands exactly on the length, and a negative step below the start. A generator that compares with the wrong bound, or wraps only one way, leaves the pointer outside the buffer. The bench walks a bit-reversed sequence through pointer feedback and checks the 0, 4, 2, 6 order, which catches a reversal over the wrong span or one applied to the pointer update. It also checks negative scaled immediates, index shifts that overflow 32 bits, and set bits above the packed increment. A design that uses the wrong scale, sign-extension or field slice would give a different address or pointer.

// File: rtl/agen_pkg.sv
// Package: shared types for the load address generator.
// Assumes: mode codes are fixed by the instruction decoder that drives mode_i.
package agen_pkg;

    typedef enum logic [2:0] {
        AM_BASE_OFS = 3'd0,
        AM_IDX_SCL  = 3'd1,
        AM_ABS_SET  = 3'd2,
        AM_POST_IMM = 3'd3,
        AM_POST_MOD = 3'd4,
        AM_BITREV   = 3'd5,
        AM_CIRC_IMM = 3'd6,
        AM_CIRC_PK  = 3'd7
    } amode_e;

endpackage

// File: rtl/agen_scale.sv
// Module: agen_scale
// Sign-extends a narrow immediate to the address width and scales it by the
// access size (left shift by the log2 size).
// Assumes: the result is used modulo 2^AW.
module agen_scale #(
    parameter int IN_W = 4,
    parameter int AW   = 32,
    parameter int SZ_W = 2
) (
    input  logic [IN_W-1:0] val_i,
    input  logic [SZ_W-1:0] lg2_i,
    output logic [AW-1:0]   res_o
);

    localparam int EXT_W = AW - IN_W;

    // sign-extend then shift by the access size
    assign res_o = {{EXT_W{val_i[IN_W-1]}}, val_i} << lg2_i;

endmodule

// File: rtl/agen_brev.sv
// Module: agen_brev
// Reverses the order of the low BREV_W bits of an address and leaves the
// upper bits in place.
// Assumes: BREV_W <= AW.
module agen_brev #(
    parameter int AW     = 32,
    parameter int BREV_W = 16
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);

    logic [BREV_W-1:0] rev;

    // one wire per reversed bit position
    for (genvar g = 0; g < BREV_W; g++) begin : g_rev
        assign rev[g] = addr_i[BREV_W-1-g];
    end

    // splice the reversed field under the untouched upper bits
    if (BREV_W < AW) begin : g_upper
        assign addr_o = {addr_i[AW-1:BREV_W], rev};
    end else begin : g_full
        assign addr_o = rev;
    end

endmodule

// File: rtl/agen_circ.sv
// Module: agen_circ
// Circular-buffer pointer update: adds a signed increment to the pointer's
// offset from the start, wraps once in either direction, and rebases on start.
// Assumes: pointer lies in [start, start+len) and |inc| < len.
module agen_circ #(
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic [AW-1:0]    ptr_i,
    input  logic [AW-1:0]    start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [AW-1:0]    inc_i,
    output logic [AW-1:0]    nxt_o
);

    localparam int PAD_W = AW + 1 - LEN_W;

    logic [AW-1:0]        off;
    logic signed [AW:0]   sum;
    logic signed [AW:0]   len_x;
    logic signed [AW:0]   wrapped;
    logic                 unused_msb;

    // offset into the buffer plus the increment, one guard bit for the sign
    always_comb begin
        off   = ptr_i - start_i;
        sum   = $signed({off[AW-1], off}) + $signed({inc_i[AW-1], inc_i});
        len_x = $signed({{PAD_W{1'b0}}, len_i});
    end

    // single correction step: past the top subtract len, below zero add len
    always_comb begin
        if (sum >= len_x) begin
            wrapped = sum - len_x;
        end else if (sum < 0) begin
            wrapped = sum + len_x;
        end else begin
            wrapped = sum;
        end
    end

    assign unused_msb = wrapped[AW];
    assign nxt_o      = start_i + wrapped[AW-1:0];

endmodule

// File: rtl/ldaddr_gen.sv
// Module: ldaddr_gen
// Effective-address and pointer-update generator for one load. Purely
// combinational; the caller registers the outputs where its pipeline needs.
// Assumes: for circular modes the pointer is inside the buffer and the scaled
// increment magnitude is below the buffer length.
module ldaddr_gen #(
    parameter int AW      = 32,
    parameter int SZ_W    = 2,
    parameter int SHIFT_W = 2,
    parameter int OFS_W   = 11,
    parameter int UIMM_W  = 6,
    parameter int INC_W   = 4,
    parameter int LEN_W   = 17,
    parameter int PINC_W  = 7,
    parameter int BREV_W  = 16
) (
    input  logic [2:0]         mode_i,
    input  logic [SZ_W-1:0]    size_lg2_i,
    input  logic [AW-1:0]      base_i,
    input  logic [AW-1:0]      index_i,
    input  logic [SHIFT_W-1:0] shamt_i,
    input  logic [OFS_W-1:0]   ofs_i,
    input  logic [UIMM_W-1:0]  uimm_i,
    input  logic [INC_W-1:0]   sinc_i,
    input  logic [AW-1:0]      modreg_i,
    input  logic [AW-1:0]      cstart_i,
    output logic [AW-1:0]      ea_o,
    output logic [AW-1:0]      ptr_nxt_o,
    output logic               ptr_we_o
);

    import agen_pkg::*;

    localparam int PINC_LSB = LEN_W;
    localparam int UPAD_W   = AW - UIMM_W;

    amode_e            mode;
    logic [AW-1:0]     ofs_scl;
    logic [AW-1:0]     sinc_scl;
    logic [AW-1:0]     pinc_scl;
    logic [AW-1:0]     circ_inc;
    logic [AW-1:0]     circ_nxt;
    logic [AW-1:0]     brev_ea;
    logic [AW-1:0]     uimm_ext;
    logic [LEN_W-1:0]  circ_len;
    logic [PINC_W-1:0] pinc_fld;

    // decode the mode code and unpack the modifier fields
    always_comb begin
        mode     = amode_e'(mode_i);
        circ_len = modreg_i[LEN_W-1:0];
        pinc_fld = modreg_i[PINC_LSB +: PINC_W];
        uimm_ext = {{UPAD_W{1'b0}}, uimm_i};
    end

    agen_scale #(.IN_W(OFS_W), .AW(AW), .SZ_W(SZ_W)) u_scl_ofs (
        .val_i (ofs_i),
        .lg2_i (size_lg2_i),
        .res_o (ofs_scl)
    );

    agen_scale #(.IN_W(INC_W), .AW(AW), .SZ_W(SZ_W)) u_scl_inc (
        .val_i (sinc_i),
        .lg2_i (size_lg2_i),
        .res_o (sinc_scl)
    );

    agen_scale #(.IN_W(PINC_W), .AW(AW), .SZ_W(SZ_W)) u_scl_pinc (
        .val_i (pinc_fld),
        .lg2_i (size_lg2_i),
        .res_o (pinc_scl)
    );

    // one circular unit shared by both circular modes
    assign circ_inc = (mode == AM_CIRC_PK) ? pinc_scl : sinc_scl;

    agen_circ #(.AW(AW), .LEN_W(LEN_W)) u_circ (
        .ptr_i   (base_i),
        .start_i (cstart_i),
        .len_i   (circ_len),
        .inc_i   (circ_inc),
        .nxt_o   (circ_nxt)
    );

    agen_brev #(.AW(AW), .BREV_W(BREV_W)) u_brev (
        .addr_i (base_i),
        .addr_o (brev_ea)
    );

    // select address, next pointer and write enable per mode
    always_comb begin
        ea_o      = base_i;
        ptr_nxt_o = base_i;
        ptr_we_o  = 1'b0;
        unique case (mode)
            AM_BASE_OFS: ea_o = base_i + ofs_scl;
            AM_IDX_SCL:  ea_o = (index_i << shamt_i) + uimm_ext;
            AM_ABS_SET: begin
                ea_o      = uimm_ext;
                ptr_nxt_o = uimm_ext;
                ptr_we_o  = 1'b1;
            end
            AM_POST_IMM: begin
                ptr_nxt_o = base_i + sinc_scl;
                ptr_we_o  = 1'b1;
            end
            AM_POST_MOD: begin
                ptr_nxt_o = base_i + modreg_i;
                ptr_we_o  = 1'b1;
            end
            AM_BITREV: begin
                ea_o      = brev_ea;
                ptr_nxt_o = base_i + modreg_i;
                ptr_we_o  = 1'b1;
            end
            AM_CIRC_IMM, AM_CIRC_PK: begin
                ptr_nxt_o = circ_nxt;
                ptr_we_o  = 1'b1;
            end
            default: ptr_we_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldaddr_gen_chk.sv
// Module: ldaddr_gen_chk
// Assertion checker for ldaddr_gen, attached by bind. Uses immediate
// assertions because the block has no clock.
// Assumes: default parameters match the bound instance.
module ldaddr_gen_chk #(
    parameter int AW     = 32,
    parameter int SZ_W   = 2,
    parameter int INC_W  = 4,
    parameter int LEN_W  = 17,
    parameter int PINC_W = 7,
    parameter int BREV_W = 16
) (
    input logic [2:0]    mode_i,
    input logic [AW-1:0] base_i,
    input logic [AW-1:0] modreg_i,
    input logic [AW-1:0] cstart_i,
    input logic [AW-1:0] ea_o,
    input logic [AW-1:0] ptr_nxt_o,
    input logic          ptr_we_o
);

    localparam int MAXSC   = 2 ** (2 ** SZ_W - 1);
    localparam int LIM_IMM = (2 ** (INC_W - 1)) * MAXSC;
    localparam int LIM_PK  = (2 ** (PINC_W - 1)) * MAXSC;
    localparam int PAD_W   = AW - LEN_W;

    logic [AW-1:0] len_x;
    logic [AW-1:0] rel_in;
    logic [AW-1:0] rel_out;
    logic          circ_ok;

    // derive buffer-relative positions for the range check
    always_comb begin
        len_x   = {{PAD_W{1'b0}}, modreg_i[LEN_W-1:0]};
        rel_in  = base_i - cstart_i;
        rel_out = ptr_nxt_o - cstart_i;
        circ_ok = (rel_in < len_x) &&
                  (((mode_i == 3'd6) && (len_x > AW'(LIM_IMM))) ||
                   ((mode_i == 3'd7) && (len_x > AW'(LIM_PK))));
    end

    // check the output relations whenever inputs are known
    always_comb begin
        if (!$isunknown({mode_i, base_i, modreg_i, cstart_i, ea_o, ptr_nxt_o, ptr_we_o})) begin
            // R1
            ptr_hold_chk: assert (ptr_we_o || (ptr_nxt_o == base_i))
                else $error("pointer changed with write enable low");
            // R4
            abs_match_chk: assert ((mode_i != 3'd2) || (ea_o == ptr_nxt_o))
                else $error("absolute-set address and pointer differ");
            // R11
            ea_is_ptr_chk: assert (!((mode_i == 3'd3) || (mode_i == 3'd4) ||
                                     (mode_i == 3'd6) || (mode_i == 3'd7)) || (ea_o == base_i))
                else $error("post-modify address is not the pointer");
            // R7
            brev_upper_chk: assert ((mode_i != 3'd5) || (ea_o[AW-1:BREV_W] == base_i[AW-1:BREV_W]))
                else $error("bit-reversed address altered upper bits");
            // R7
            brev_ones_chk: assert ((mode_i != 3'd5) ||
                                   ($countones(ea_o[BREV_W-1:0]) == $countones(base_i[BREV_W-1:0])))
                else $error("bit-reversed field lost or gained bits");
            // R8
            circ_range_chk: assert (!circ_ok || (rel_out < len_x))
                else $error("circular pointer left the buffer");
        end
    end

endmodule

bind ldaddr_gen ldaddr_gen_chk #(
    .AW(AW), .SZ_W(SZ_W), .INC_W(INC_W), .LEN_W(LEN_W), .PINC_W(PINC_W), .BREV_W(BREV_W)
) u_chk (
    .mode_i    (mode_i),
    .base_i    (base_i),
    .modreg_i  (modreg_i),
    .cstart_i  (cstart_i),
    .ea_o      (ea_o),
    .ptr_nxt_o (ptr_nxt_o),
    .ptr_we_o  (ptr_we_o)
);

// File: tb/test_ldaddr_gen.sv
// Bench: test_ldaddr_gen
// Table of hand-computed vectors, then pointer-feedback walks and a sweep
// against a reference model written from the requirements.
module test_ldaddr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;
    localparam int NSWEEP     = 240;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  size;
        logic [31:0] base;
        logic [31:0] index;
        logic [1:0]  shamt;
        logic [10:0] ofs;
        logic [5:0]  uimm;
        logic [3:0]  sinc;
        logic [31:0] modreg;
        logic [31:0] cstart;
        logic [31:0] e_ea;
        logic [31:0] e_ptr;
        logic        e_we;
    } vec_t;

    // mode size base index sh ofs uimm sinc modreg cstart | ea ptr we
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd2, 32'h1000, 32'h0, 2'd0, 11'h7FD, 6'h0, 4'h0, 32'h0, 32'h0, 32'hFF4, 32'h1000, 1'b0},               // R2 R1
        '{3'd0, 2'd1, 32'h2000, 32'h0, 2'd0, 11'd5, 6'h0, 4'h0, 32'h0, 32'h0, 32'h200A, 32'h2000, 1'b0},                // R2
        '{3'd1, 2'd0, 32'h5555, 32'h10, 2'd3, 11'h0, 6'h3F, 4'h0, 32'h0, 32'h0, 32'hBF, 32'h5555, 1'b0},                // R3 R1
        '{3'd1, 2'd0, 32'h0, 32'h8000_0001, 2'd1, 11'h0, 6'h2, 4'h0, 32'h0, 32'h0, 32'h4, 32'h0, 1'b0},                 // R3
        '{3'd2, 2'd0, 32'h9999, 32'h0, 2'd0, 11'h0, 6'h2A, 4'h0, 32'h0, 32'h0, 32'h2A, 32'h2A, 1'b1},                   // R4
        '{3'd3, 2'd3, 32'h100, 32'h0, 2'd0, 11'h0, 6'h0, 4'hF, 32'h0, 32'h0, 32'h100, 32'hF8, 1'b1},                    // R5 R11
        '{3'd3, 2'd0, 32'h100, 32'h0, 2'd0, 11'h0, 6'h0, 4'h7, 32'h0, 32'h0, 32'h100, 32'h107, 1'b1},                   // R5
        '{3'd4, 2'd0, 32'h200, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'hFFFF_FFF0, 32'h0, 32'h200, 32'h1F0, 1'b1},           // R6 R11
        '{3'd5, 2'd0, 32'hABCD_0001, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'h10, 32'h0, 32'hABCD_8000, 32'hABCD_0011, 1'b1}, // R7
        '{3'd5, 2'd0, 32'h2000, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'h2000, 32'h0, 32'h4, 32'h4000, 1'b1},                // R7
        '{3'd6, 2'd1, 32'h1004, 32'h0, 2'd0, 11'h0, 6'h0, 4'h1, 32'h6, 32'h1000, 32'h1004, 32'h1000, 1'b1},             // R8 wrap up
        '{3'd6, 2'd1, 32'h1000, 32'h0, 2'd0, 11'h0, 6'h0, 4'hF, 32'h6, 32'h1000, 32'h1000, 32'h1004, 1'b1},             // R9 wrap down
        '{3'd7, 2'd1, 32'h2004, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'h0004_0008, 32'h2000, 32'h2004, 32'h2000, 1'b1},     // R10 R8
        '{3'd7, 2'd2, 32'h2000, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'h00FE_0008, 32'h2000, 32'h2000, 32'h2004, 1'b1},     // R10 R9
        '{3'd6, 2'd1, 32'h1000, 32'h0, 2'd0, 11'h0, 6'h0, 4'h1, 32'h6, 32'h1000, 32'h1000, 32'h1002, 1'b1},             // R8 no wrap
        '{3'd7, 2'd1, 32'h2004, 32'h0, 2'd0, 11'h0, 6'h0, 4'h0, 32'hFF04_0008, 32'h2000, 32'h2004, 32'h2000, 1'b1}      // R10 top bits
    };

    logic        clk;
    logic        rst_n;
    logic        done;
    logic [2:0]  mode;
    logic [1:0]  size;
    logic [31:0] base;
    logic [31:0] index;
    logic [1:0]  shamt;
    logic [10:0] ofs;
    logic [5:0]  uimm;
    logic [3:0]  sinc;
    logic [31:0] modreg;
    logic [31:0] cstart;
    logic [31:0] ea;
    logic [31:0] pnx;
    logic        we;
    int          n_chk;
    int          n_fail;

    ldaddr_gen i_ldaddr_gen (
        .mode_i     (mode),
        .size_lg2_i (size),
        .base_i     (base),
        .index_i    (index),
        .shamt_i    (shamt),
        .ofs_i      (ofs),
        .uimm_i     (uimm),
        .sinc_i     (sinc),
        .modreg_i   (modreg),
        .cstart_i   (cstart),
        .ea_o       (ea),
        .ptr_nxt_o  (pnx),
        .ptr_we_o   (we)
    );

    // free-running bench clock
    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        mode = 3'd0; size = 2'd0; base = 32'h0; index = 32'h0; shamt = 2'd0;
        ofs = 11'h0; uimm = 6'h0; sinc = 4'h0; modreg = 32'h0; cstart = 32'h0;
    endtask

    // reference model built from the requirement text
    function automatic logic [64:0] ref_model(
        input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
        input logic [31:0] ix, input logic [1:0] sh, input logic [10:0] o,
        input logic [5:0] u, input logic [3:0] si, input logic [31:0] mr,
        input logic [31:0] cs);
        logic [31:0] r_ea, r_ptr, incv, rv;
        logic        r_we;
        longint      len, off, sum;
        r_ea = b; r_ptr = b; r_we = (m >= 3'd2);
        incv = (m == 3'd7) ? (32'($signed(mr[23:17])) << s) : (32'($signed(si)) << s);
        case (m)
            3'd0: r_ea = b + (32'($signed(o)) << s);
            3'd1: r_ea = (ix << sh) + 32'(u);
            3'd2: begin r_ea = 32'(u); r_ptr = 32'(u); end
            3'd3: r_ptr = b + incv;
            3'd4: r_ptr = b + mr;
            3'd5: begin
                rv = b;
                for (int k = 0; k < 16; k++) rv[k] = b[15-k];
                r_ea = rv; r_ptr = b + mr;
            end
            default: begin
                len = longint'(mr[16:0]);
                off = longint'($signed(b - cs));
                sum = off + longint'($signed(incv));
                if (sum >= len) sum = sum - len;
                else if (sum < 0) sum = sum + len;
                r_ptr = cs + 32'(sum);
            end
        endcase
        return {r_we, r_ea, r_ptr};
    endfunction

    // watchdog: a hung run is counted as a failure
    initial begin
        done = 1'b0;
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // stimulus and checking
    initial begin
        logic [64:0] r;
        n_chk = 0; n_fail = 0;
        rst_n = 1'b0;
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R2: idle inputs give a zero address, no pointer write
        #1;
        chk("R2", "reset ea", ea, 32'h0);
        chk("R1", "reset ptr", pnx, 32'h0);
        chk("R1", "reset we", {31'h0, we}, 32'h0);
        rst_n = 1'b1;

        // table of hand-computed vectors
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode = VECS[v].mode; size = VECS[v].size; base = VECS[v].base;
            index = VECS[v].index; shamt = VECS[v].shamt; ofs = VECS[v].ofs;
            uimm = VECS[v].uimm; sinc = VECS[v].sinc; modreg = VECS[v].modreg;
            cstart = VECS[v].cstart;
            #1;
            chk($sformatf("R%0d vec%0d", 1 + int'(VECS[v].mode), v), "ea", ea, VECS[v].e_ea);
            chk($sformatf("R%0d vec%0d", 1 + int'(VECS[v].mode), v), "ptr", pnx, VECS[v].e_ptr);
            chk($sformatf("R1 vec%0d", v), "we", {31'h0, we}, {31'h0, VECS[v].e_we});
        end

        // R7: bit-reversed walk with pointer feedback gives 0,4,2,6
        clear_inputs();
        mode = 3'd5; modreg = 32'h2000;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] exp_ea;
            exp_ea = (k == 0) ? 32'd0 : (k == 1) ? 32'd4 : (k == 2) ? 32'd2 : 32'd6;
            @(negedge clk);
            #1;
            chk("R7 walk", "ea", ea, exp_ea);
            base = pnx;
        end

        // R8 R11: circular walk, length 6, step 2, returns to start
        clear_inputs();
        mode = 3'd6; size = 2'd1; sinc = 4'h1; modreg = 32'h6;
        cstart = 32'h4000; base = 32'h4000;
        for (int k = 0; k < 5; k++) begin
            logic [31:0] exp_ea;
            exp_ea = 32'h4000 + 32'((2 * k) % 6);
            @(negedge clk);
            #1;
            chk("R8 walk", "ea", ea, exp_ea);
            base = pnx;
        end

        // R9 R10: packed-field circular walk downward, step -8
        clear_inputs();
        mode = 3'd7; size = 2'd3; modreg = {8'hA5, 7'h7F, 17'd24};
        cstart = 32'h8000; base = 32'h8000;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] exp_p;
            exp_p = (k == 0) ? 32'h8010 : (k == 1) ? 32'h8008 : (k == 2) ? 32'h8000 : 32'h8010;
            @(negedge clk);
            #1;
            chk("R9 pk walk", "ptr", pnx, exp_p);
            base = pnx;
        end

        // sweep every mode against the reference model (R1-style tags per mode)
        for (int i = 0; i < NSWEEP; i++) begin
            logic [31:0] len;
            @(negedge clk);
            mode = 3'(i % 8); size = 2'($urandom_range(0, 3));
            index = $urandom(); shamt = 2'($urandom_range(0, 3));
            ofs = 11'($urandom()); uimm = 6'($urandom()); sinc = 4'($urandom());
            cstart = $urandom();
            if (mode >= 3'd6) begin
                len    = 32'($urandom_range(600, 999));
                modreg = {8'($urandom()), 7'($urandom()), len[16:0]};
                base   = cstart + 32'($urandom_range(0, 32'(len - 1)));
            end else begin
                modreg = $urandom();
                base   = $urandom();
            end
            #1;
            r = ref_model(mode, size, base, index, shamt, ofs, uimm, sinc, modreg, cstart);
            chk($sformatf("R%0d sweep%0d", (mode >= 3'd6) ? 8 : 2 + int'(mode), i), "ea", ea, r[63:32]);
            chk($sformatf("R%0d sweep%0d", (mode == 3'd7) ? 10 : (mode == 3'd6) ? 8 : 2 + int'(mode), i),
                "ptr", pnx, r[31:0]);
            chk($sformatf("R1 sweep%0d", i), "we", {31'h0, we}, {31'h0, r[64]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule